// File: doc/BRIEF.md
# Heartbeat Watchdog Monitor

This block supervises a processor by watching a heartbeat pin that software toggles. Any change of level, rising or falling, counts as a sign of life. Each change restarts a full timeout window. If a whole window passes with no change, the active-low watchdog flag drops. It stays low until the heartbeat moves again. The window length comes from the clock frequency and the timeout in milliseconds, given as parameters. The default is a 1.6 second window at 50 MHz.

The monitor has three ways of being held idle, cleared and not counting:

- the system is in reset;
- a heartbeat-enable input is low, which marks a disconnected or three-stated heartbeat source;
- after either of these, until the first heartbeat change arrives.

While idle, the flag is high.

A supply-good input overrides everything. While it is false the flag is low. The flag rises again as soon as supply is good, with no minimum low time, unless a timeout is also pending. The heartbeat passes through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the one before it.

Top module: `wdt_heartbeat_monitor`

## Requirements
- R1: After a heartbeat change starts or restarts the count, `wdo_n` stays high through the next TC+2 clock edges and goes low on the edge TC+3 after the change. A change is a level change of `hb_in` set up before a rising clock edge. TC = (CLK_HZ/1000)*TIMEOUT_MS.
- R2: Once low after a timeout, `wdo_n` stays low for any length of time until a heartbeat change arrives. It returns high on the third rising edge after that change.
- R3: Rising and falling changes of `hb_in` both count as activity. Changes spaced closer than the window keep `wdo_n` high indefinitely.
- R4: While `host_rst` is 1, the monitor is cleared and `wdo_n` is high (given supply good). Heartbeat changes seen during this time are ignored. After `host_rst` returns to 0, no timeout occurs until the first heartbeat change, and counting then follows R1.
- R5: While `hb_en` is 0, the monitor is cleared, `wdo_n` is high (given supply good), and heartbeat changes are ignored. This also clears a pending timeout from the next clock edge on.
- R6: While `supply_ok` is 0, `wdo_n` is 0 in the same cycle, including during block reset. When `supply_ok` returns to 1, `wdo_n` goes high at once unless a timeout is pending.
- R7: While `rst_n` is 0, the monitor is idle and `wdo_n` equals `supply_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_rst | input | 1 | System reset state, 1 = in reset (clears monitor) |
| hb_en | input | 1 | Heartbeat source connected, 0 = disconnected (clears monitor) |
| hb_in | input | 1 | Asynchronous heartbeat from processor |
| supply_ok | input | 1 | Supply-good flag, 0 forces `wdo_n` low |
| wdo_n | output | 1 | Active-low watchdog flag |

## Verification
A wrong count or state shows at `wdo_n` as a timeout edge that is early or late against the TC+3 cycle point after the last heartbeat change. It can also show as a flag that falls while idle, or one that fails to recover three cycles after a change. The bench samples exactly on both sides of that boundary, so an off-by-one is caught within one window. An edge detector that misses one polarity, or a clear path that leaks, shows within one window of the stimulus that should have kept the flag high.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

    function automatic int unsigned wd_window(input int unsigned clk_hz,
                                              input int unsigned timeout_ms);
        return (clk_hz / 1000) * timeout_ms;
    endfunction

endpackage

// File: rtl/wdt_hb_sync.sv
module wdt_hb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    output logic hb_edge
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = hb_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev     = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hb_edge = s_q.chain[STAGES-1] ^ s_q.prev;

    // an edge pulse lasts exactly one cycle for a stable input
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_edge && $stable(hb_in) && $past($stable(hb_in))) |=> !hb_edge); // R3
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hb_edge,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] SAT  = CW'(LIMIT);

    typedef struct packed {
        wd_state_e     st;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d.st  = WD_IDLE;
            t_d.cnt = '0;
        end else begin
            unique case (t_q.st)
                WD_IDLE: begin
                    if (hb_edge) begin
                        t_d.st  = WD_RUN;
                        t_d.cnt = '0;
                    end
                end
                WD_RUN: begin
                    if (hb_edge) begin
                        t_d.cnt = '0;
                    end else if (t_q.cnt == LAST) begin
                        t_d.st  = WD_TRIP;
                        t_d.cnt = SAT;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end
                WD_TRIP: begin
                    if (hb_edge) begin
                        t_d.st  = WD_RUN;
                        t_d.cnt = '0;
                    end
                end
                default: begin
                    t_d.st  = WD_IDLE;
                    t_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: WD_IDLE, cnt: '0};
        else        t_q <= t_d;
    end

    assign expired = (t_q.st == WD_TRIP);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= SAT); // R1
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (t_q.st == WD_IDLE && t_q.cnt == '0)); // R4
    AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && hb_edge) |=> (t_q.st == WD_RUN && t_q.cnt == '0)); // R3
    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear && !hb_edge) |=> expired); // R2
    AST_TRIP_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> ($past(t_q.cnt) == LAST && $past(t_q.st) == WD_RUN)); // R1
endmodule

// File: rtl/wdt_heartbeat_monitor.sv
module wdt_heartbeat_monitor
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TIMEOUT_MS  = 1600,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst,
    input  logic hb_en,
    input  logic hb_in,
    input  logic supply_ok,
    output logic wdo_n
);
    localparam int unsigned LIMIT = wd_window(CLK_HZ, TIMEOUT_MS);

    logic hb_edge;
    logic hold_clear;
    logic expired;

    wdt_hb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .hb_in  (hb_in),
        .hb_edge(hb_edge)
    );

    assign hold_clear = host_rst | ~hb_en;

    wdt_timer #(.LIMIT(LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hold_clear),
        .hb_edge(hb_edge),
        .expired(expired)
    );

    assign wdo_n = supply_ok & ~expired;

    AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !wdo_n); // R6
    AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_en |=> (wdo_n || !supply_ok)); // R5
    AST_HOSTRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> (wdo_n || !supply_ok)); // R4
endmodule

// File: tb/wdt_heartbeat_monitor_tb.sv
module wdt_heartbeat_monitor_tb;
    localparam int unsigned CLK_HZ     = 100_000;
    localparam int unsigned TIMEOUT_MS = 1;
    localparam int unsigned TC         = (CLK_HZ / 1000) * TIMEOUT_MS;

    logic clk = 1'b0;
    logic rst_n, host_rst, hb_en, hb_in, supply_ok;
    logic wdo_n;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;

    always #2.5 clk = ~clk;

    wdt_heartbeat_monitor #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TIMEOUT_MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .hb_en(hb_en),
        .hb_in(hb_in), .supply_ok(supply_ok), .wdo_n(wdo_n)
    );

    // {en, host_rst, supply, toggle, wait[15:0], expected wdo_n, req tag}
    localparam int NV = 33;
    localparam logic [24:0] VEC [NV] = '{
        {4'b1010, 16'd200,        1'b1, 4'd4}, // R4 no count before first edge
        {4'b1011, 16'(TC+2),      1'b1, 4'd1}, // R1 still high at boundary
        {4'b1010, 16'd1,          1'b0, 4'd1}, // R1 falls at TC+3
        {4'b1010, 16'(3*TC),      1'b0, 4'd2}, // R2 stays low
        {4'b1011, 16'd2,          1'b0, 4'd2}, // R2 not yet back after 2
        {4'b1010, 16'd1,          1'b1, 4'd2}, // R2 back on 3rd edge (falling change, R3)
        {4'b1011, 16'(TC/2),      1'b1, 4'd3}, // R3 restart
        {4'b1011, 16'(TC/2),      1'b1, 4'd3}, // R3 restart
        {4'b1011, 16'(TC/2),      1'b1, 4'd3}, // R3 restart
        {4'b1011, 16'(TC/2),      1'b1, 4'd3}, // R3 restart
        {4'b1010, 16'(TC/2+2),    1'b1, 4'd3}, // R3 window counted from last change
        {4'b1010, 16'd1,          1'b0, 4'd1}, // R1 timeout
        {4'b1011, 16'd5,          1'b1, 4'd2}, // R2 recover
        {4'b1000, 16'd1,          1'b0, 4'd6}, // R6 supply low forces low
        {4'b1010, 16'd1,          1'b1, 4'd6}, // R6 immediate return
        {4'b0010, 16'd1,          1'b1, 4'd5}, // R5 disabled
        {4'b0010, 16'(3*TC),      1'b1, 4'd5}, // R5 no timeout while disabled
        {4'b1010, 16'(2*TC),      1'b1, 4'd5}, // R5 re-enable waits for edge
        {4'b1011, 16'(TC+3),      1'b0, 4'd1}, // R1 timeout again
        {4'b0010, 16'd1,          1'b1, 4'd5}, // R5 clears pending timeout
        {4'b1010, 16'(2*TC),      1'b1, 4'd5}, // R5 still idle
        {4'b0011, 16'd5,          1'b1, 4'd5}, // R5 change while disabled
        {4'b1010, 16'(2*TC),      1'b1, 4'd5}, // R5 that change was ignored
        {4'b1111, 16'(2*TC),      1'b1, 4'd4}, // R4 change during host reset
        {4'b1010, 16'(2*TC),      1'b1, 4'd4}, // R4 ignored after release
        {4'b1011, 16'(TC+2),      1'b1, 4'd4}, // R4 first edge starts count
        {4'b1010, 16'd1,          1'b0, 4'd4}, // R4 then times out per R1
        {4'b1000, 16'd1,          1'b0, 4'd6}, // R6 supply low while tripped
        {4'b1010, 16'd1,          1'b0, 4'd6}, // R6 timeout still pending
        {4'b1110, 16'd1,          1'b1, 4'd4}, // R4 host reset clears trip
        {4'b1100, 16'd1,          1'b0, 4'd6}, // R6 supply low in host reset
        {4'b1010, 16'(2*TC),      1'b1, 4'd4}, // R4 idle after release
        {4'b1011, 16'd3,          1'b1, 4'd3}  // R3 running
    };

    task automatic check(input logic exp, input int tag, input string what);
        n_chk++;
        if (wdo_n !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: wdo_n=%b expected %b at %0t", tag, what, wdo_n, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200_000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: wdo_n=%b expected run end", wdo_n);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; host_rst = 1'b0; hb_en = 1'b1; hb_in = 1'b0; supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        #1 check(1'b1, 7, "block reset idle high");              // R7
        supply_ok = 1'b0;
        #1 check(1'b0, 7, "block reset follows supply");         // R7 / R6
        supply_ok = 1'b1;
        hb_in = 1'b1;
        repeat (4) @(negedge clk);
        #1 check(1'b1, 7, "changes ignored in block reset");     // R7
        hb_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            hb_en     = VEC[i][24];
            host_rst  = VEC[i][23];
            supply_ok = VEC[i][22];
            if (VEC[i][21]) hb_in = ~hb_in;
            repeat (int'(VEC[i][20:5])) @(negedge clk);
            #1 check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end
        // directed: trip, then block reset returns idle
        repeat (TC + 3) @(negedge clk);
        #1 check(1'b0, 1, "timeout before block reset");         // R1
        rst_n = 1'b0;
        #1 check(1'b1, 7, "async block reset clears trip");      // R7
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * TC) @(negedge clk);
        #1 check(1'b1, 7, "idle after block reset");             // R7
        finish_run();
    end
endmodule